// File: doc/BRIEF.md
# Banked UART Register Decoder

This block is the host-facing register file and address decoder of a single 16550-style UART channel. A synchronous host bus (chip select, read strobe, write strobe, 3-bit address, 8-bit write data) reaches eight locations. The register behind each location depends on the current bank. The bank comes from the line-control value: bit 7 clear selects the normal bank, bit 7 set selects the divisor bank, and the exact value 0xBF selects the enhanced bank. One feature-control bit picks what sits at location 7 of the normal bank.

The block holds the configuration bytes: divisor, interrupt enable, line control, modem control, scratch, feature control, enhanced function, and two pairs of flow-control characters. It presents them as outputs to the rest of the channel. Status bytes from the FIFOs and the line logic come in as inputs and are returned on reads. Accesses that act on the FIFOs produce one-cycle strobes: receive pop, transmit push, FIFO-control write, trigger-level write and mode-select write. A low level on a separate select input turns every read into a read of the FIFO status byte.

Top module: `uart_bank_regs`

## Requirements
- R1: Location 3 is the line-control register. It can be read and written in every bank, and its written value shows on `lcrOut` after the write edge.
- R2: With line-control bit 7 at 0, a read of location 0 returns `rxData` and pulses `rxPop` in the cycle after the read edge. A write of location 0 pulses `txPush`, with `strbData` carrying the written byte, in the cycle after the write edge.
- R3: With bit 7 at 0, location 1 is interrupt enable (`ierOut`) and location 4 is modem control (`mcrOut`), both read/write. A read of location 2 returns `isrIn`. A write of location 2 pulses `fcrWr` with the byte on `strbData` one cycle later, in any bank other than enhanced.
- R4: Outside the enhanced bank, location 5 reads `lsrIn` and location 6 reads `msrIn`. Writes to either location change no register and fire no strobe.
- R5: Outside the enhanced bank, location 7 depends on `fctrOut[6]`. At 0 it is a read/write scratch byte. At 1 a read returns `fifoLevel` and a write pulses `emsrWr` with the byte on `strbData` one cycle later.
- R6: With bit 7 at 1 and line control not equal to 0xBF, locations 0 and 1 hold the divisor low and high bytes (`divisorOut[7:0]`, `divisorOut[15:8]`). Reads and writes of these locations fire no strobe.
- R7: In the divisor bank, while the divisor is 0x0000, a read of location 0 returns parameter `REV_CODE` and a read of location 1 returns parameter `DEV_ID`.
- R8: With line control equal to 0xBF, the locations map as follows: 0 reads `fifoLevel` and on write pulses `trgWr` with the byte; 1 is feature control; 2 is enhanced function; 4, 5, 6 and 7 are the first on-character, second on-character, first off-character and second off-character (`xonChars[7:0]`, `xonChars[15:8]`, `xoffChars[7:0]`, `xoffChars[15:8]`). No receive, transmit or FIFO-control strobe fires in this bank.
- R9: While `fifoStatSelN` is 0, any read returns `fifoStat` whatever the address, and the read fires no strobe.
- R10: After reset, every configuration output and every strobe is 0. `rdata` is 0 whenever no read is in progress (`cs` and `rd` high with `wr` low).
- R11: All strobes are registered. Each is high only in the cycle right after the accepting edge, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe (takes priority over rd) |
| addr | input | 3 | Register location |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| fifoStatSelN | input | 1 | Low: reads return FIFO status |
| rxData | input | 8 | Head of receive FIFO |
| isrIn | input | 8 | Interrupt status byte |
| lsrIn | input | 8 | Line status byte |
| msrIn | input | 8 | Modem status byte |
| fifoLevel | input | 8 | FIFO level count |
| fifoStat | input | 8 | FIFO status byte |
| rxPop | output | 1 | Receive pop strobe |
| txPush | output | 1 | Transmit push strobe |
| fcrWr | output | 1 | FIFO-control write strobe |
| trgWr | output | 1 | Trigger-level write strobe |
| emsrWr | output | 1 | Mode-select write strobe |
| strbData | output | 8 | Byte that goes with a write strobe |
| lcrOut | output | 8 | Line control |
| ierOut | output | 8 | Interrupt enable |
| mcrOut | output | 8 | Modem control |
| fctrOut | output | 8 | Feature control |
| efrOut | output | 8 | Enhanced function |
| divisorOut | output | 16 | Divisor {high, low} |
| xonChars | output | 16 | On-characters {second, first} |
| xoffChars | output | 16 | Off-characters {second, first} |

## Verification
Read data is combinational. It is due in the same cycle as the read request, so the bench drives each access just after a falling edge and samples `rdata` one time unit later. Register contents and strobes change on the next rising edge. The bench therefore compares the configuration outputs and the strobe outputs at the following falling edge, against the expectation it stored when the access was issued. A bench model of the bank rules tracks every register. The model also gives each check its requirement tag, so random traffic across all three banks and the status override is scored per requirement.

// File: rtl/uart_bank_regs_pkg.sv
package uart_bank_regs_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] ENH_KEY = 8'hBF;

  typedef enum logic [4:0] {
    W_NONE, W_THR, W_DLL, W_DLM, W_IER, W_FCR, W_LCR, W_MCR, W_SPR,
    W_EMSR, W_TRG, W_FCTR, W_EFR, W_XON1, W_XON2, W_XOFF1, W_XOFF2
  } wrSel_e;

  typedef enum logic [4:0] {
    S_ZERO, S_RHR, S_DLL, S_DLM, S_REV, S_DEVID, S_IER, S_ISR, S_LCR,
    S_MCR, S_LSR, S_MSR, S_SPR, S_FLVL, S_FCTR, S_EFR, S_XON1, S_XON2,
    S_XOFF1, S_XOFF2, S_FSTAT
  } rdSel_e;

  typedef struct packed {
    wrSel_e wrSel;
    rdSel_e rdSel;
    logic   rxPop;
  } ctrl_t;
endpackage

// File: rtl/uart_bank_ctrl.sv
module uart_bank_ctrl
  import uart_bank_regs_pkg::*;
(
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              fifoStatSelN,
  input  logic [DATA_W-1:0] lcr,
  input  logic              fctrLoc7Sel,
  input  logic              divZero,
  output ctrl_t             ctrl
);
  logic wrAcc, rdAcc, isEnh, isDiv;

  always_comb begin
    wrAcc = cs & wr;
    rdAcc = cs & rd & ~wr;
    isEnh = (lcr == ENH_KEY);
    isDiv = lcr[DATA_W-1] & ~isEnh;
  end

  always_comb begin
    ctrl.wrSel = W_NONE;
    if (wrAcc) begin
      unique case (addr)
        3'd0: ctrl.wrSel = isEnh ? W_TRG  : (isDiv ? W_DLL : W_THR);
        3'd1: ctrl.wrSel = isEnh ? W_FCTR : (isDiv ? W_DLM : W_IER);
        3'd2: ctrl.wrSel = isEnh ? W_EFR  : W_FCR;
        3'd3: ctrl.wrSel = W_LCR;
        3'd4: ctrl.wrSel = isEnh ? W_XON1 : W_MCR;
        3'd5: ctrl.wrSel = isEnh ? W_XON2 : W_NONE;
        3'd6: ctrl.wrSel = isEnh ? W_XOFF1 : W_NONE;
        default: ctrl.wrSel = isEnh ? W_XOFF2 : (fctrLoc7Sel ? W_EMSR : W_SPR);
      endcase
    end
  end

  always_comb begin
    ctrl.rdSel = S_ZERO;
    if (rdAcc) begin
      if (!fifoStatSelN) begin
        ctrl.rdSel = S_FSTAT;
      end else begin
        unique case (addr)
          3'd0: ctrl.rdSel = isEnh ? S_FLVL :
                             (isDiv ? (divZero ? S_REV : S_DLL) : S_RHR);
          3'd1: ctrl.rdSel = isEnh ? S_FCTR :
                             (isDiv ? (divZero ? S_DEVID : S_DLM) : S_IER);
          3'd2: ctrl.rdSel = isEnh ? S_EFR : S_ISR;
          3'd3: ctrl.rdSel = S_LCR;
          3'd4: ctrl.rdSel = isEnh ? S_XON1 : S_MCR;
          3'd5: ctrl.rdSel = isEnh ? S_XON2 : S_LSR;
          3'd6: ctrl.rdSel = isEnh ? S_XOFF1 : S_MSR;
          default: ctrl.rdSel = isEnh ? S_XOFF2 : (fctrLoc7Sel ? S_FLVL : S_SPR);
        endcase
      end
    end
    ctrl.rxPop = (ctrl.rdSel == S_RHR);
  end
endmodule

// File: rtl/uart_bank_dp.sv
module uart_bank_dp
  import uart_bank_regs_pkg::*;
#(
  parameter logic [DATA_W-1:0] REV_CODE = 8'h02,
  parameter logic [DATA_W-1:0] DEV_ID   = 8'h64
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_t               ctrl,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W-1:0]   rxData,
  input  logic [DATA_W-1:0]   isrIn,
  input  logic [DATA_W-1:0]   lsrIn,
  input  logic [DATA_W-1:0]   msrIn,
  input  logic [DATA_W-1:0]   fifoLevel,
  input  logic [DATA_W-1:0]   fifoStat,
  output logic [DATA_W-1:0]   rdata,
  output logic                rxPop,
  output logic                txPush,
  output logic                fcrWr,
  output logic                trgWr,
  output logic                emsrWr,
  output logic [DATA_W-1:0]   strbData,
  output logic [DATA_W-1:0]   lcr,
  output logic [DATA_W-1:0]   ier,
  output logic [DATA_W-1:0]   mcr,
  output logic [DATA_W-1:0]   fctr,
  output logic [DATA_W-1:0]   efr,
  output logic [2*DATA_W-1:0] divisor,
  output logic [2*DATA_W-1:0] xonChars,
  output logic [2*DATA_W-1:0] xoffChars
);
  localparam int NUM_FLOW = 4;

  logic [DATA_W-1:0] spr;
  logic [DATA_W-1:0] flowChar [NUM_FLOW];
  logic              strbWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lcr     <= '0;
      ier     <= '0;
      mcr     <= '0;
      fctr    <= '0;
      efr     <= '0;
      spr     <= '0;
      divisor <= '0;
    end else begin
      unique case (ctrl.wrSel)
        W_LCR:   lcr  <= wdata;
        W_IER:   ier  <= wdata;
        W_MCR:   mcr  <= wdata;
        W_FCTR:  fctr <= wdata;
        W_EFR:   efr  <= wdata;
        W_SPR:   spr  <= wdata;
        W_DLL:   divisor[DATA_W-1:0]        <= wdata;
        W_DLM:   divisor[2*DATA_W-1:DATA_W] <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar gi = 0; gi < NUM_FLOW; gi++) begin : g_flow
    localparam wrSel_e SEL = (gi == 0) ? W_XON1 : (gi == 1) ? W_XON2 :
                             (gi == 2) ? W_XOFF1 : W_XOFF2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   flowChar[gi] <= '0;
      else if (ctrl.wrSel == SEL)  flowChar[gi] <= wdata;
    end
  end

  assign xonChars  = {flowChar[1], flowChar[0]};
  assign xoffChars = {flowChar[3], flowChar[2]};

  assign strbWr = (ctrl.wrSel == W_THR) || (ctrl.wrSel == W_FCR) ||
                  (ctrl.wrSel == W_TRG) || (ctrl.wrSel == W_EMSR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPop    <= 1'b0;
      txPush   <= 1'b0;
      fcrWr    <= 1'b0;
      trgWr    <= 1'b0;
      emsrWr   <= 1'b0;
      strbData <= '0;
    end else begin
      rxPop    <= ctrl.rxPop;
      txPush   <= (ctrl.wrSel == W_THR);
      fcrWr    <= (ctrl.wrSel == W_FCR);
      trgWr    <= (ctrl.wrSel == W_TRG);
      emsrWr   <= (ctrl.wrSel == W_EMSR);
      strbData <= strbWr ? wdata : '0;
    end
  end

  always_comb begin
    unique case (ctrl.rdSel)
      S_RHR:   rdata = rxData;
      S_DLL:   rdata = divisor[DATA_W-1:0];
      S_DLM:   rdata = divisor[2*DATA_W-1:DATA_W];
      S_REV:   rdata = REV_CODE;
      S_DEVID: rdata = DEV_ID;
      S_IER:   rdata = ier;
      S_ISR:   rdata = isrIn;
      S_LCR:   rdata = lcr;
      S_MCR:   rdata = mcr;
      S_LSR:   rdata = lsrIn;
      S_MSR:   rdata = msrIn;
      S_SPR:   rdata = spr;
      S_FLVL:  rdata = fifoLevel;
      S_FCTR:  rdata = fctr;
      S_EFR:   rdata = efr;
      S_XON1:  rdata = flowChar[0];
      S_XON2:  rdata = flowChar[1];
      S_XOFF1: rdata = flowChar[2];
      S_XOFF2: rdata = flowChar[3];
      S_FSTAT: rdata = fifoStat;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_bank_regs_pkg::*;
#(
  parameter logic [7:0] REV_CODE = 8'h02,
  parameter logic [7:0] DEV_ID   = 8'h64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cs,
  input  logic        rd,
  input  logic        wr,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        fifoStatSelN,
  input  logic [7:0]  rxData,
  input  logic [7:0]  isrIn,
  input  logic [7:0]  lsrIn,
  input  logic [7:0]  msrIn,
  input  logic [7:0]  fifoLevel,
  input  logic [7:0]  fifoStat,
  output logic        rxPop,
  output logic        txPush,
  output logic        fcrWr,
  output logic        trgWr,
  output logic        emsrWr,
  output logic [7:0]  strbData,
  output logic [7:0]  lcrOut,
  output logic [7:0]  ierOut,
  output logic [7:0]  mcrOut,
  output logic [7:0]  fctrOut,
  output logic [7:0]  efrOut,
  output logic [15:0] divisorOut,
  output logic [15:0] xonChars,
  output logic [15:0] xoffChars
);
  localparam int LOC7_SEL_BIT = 6;

  ctrl_t ctrl;

  uart_bank_ctrl i_ctrl (
    .cs          (cs),
    .rd          (rd),
    .wr          (wr),
    .addr        (addr),
    .fifoStatSelN(fifoStatSelN),
    .lcr         (lcrOut),
    .fctrLoc7Sel (fctrOut[LOC7_SEL_BIT]),
    .divZero     (divisorOut == '0),
    .ctrl        (ctrl)
  );

  uart_bank_dp #(.REV_CODE(REV_CODE), .DEV_ID(DEV_ID)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .wdata    (wdata),
    .rxData   (rxData),
    .isrIn    (isrIn),
    .lsrIn    (lsrIn),
    .msrIn    (msrIn),
    .fifoLevel(fifoLevel),
    .fifoStat (fifoStat),
    .rdata    (rdata),
    .rxPop    (rxPop),
    .txPush   (txPush),
    .fcrWr    (fcrWr),
    .trgWr    (trgWr),
    .emsrWr   (emsrWr),
    .strbData (strbData),
    .lcr      (lcrOut),
    .ier      (ierOut),
    .mcr      (mcrOut),
    .fctr     (fctrOut),
    .efr      (efrOut),
    .divisor  (divisorOut),
    .xonChars (xonChars),
    .xoffChars(xoffChars)
  );
endmodule

// File: rtl/uart_bank_regs_chk.sv
module uart_bank_regs_chk #(
  parameter logic [7:0] REV_CODE = 8'h02,
  parameter logic [7:0] DEV_ID   = 8'h64
) (
  input logic        clk,
  input logic        rstN,
  input logic        cs,
  input logic        rd,
  input logic        wr,
  input logic [2:0]  addr,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic        fifoStatSelN,
  input logic [7:0]  fifoStat,
  input logic        rxPop,
  input logic        txPush,
  input logic        fcrWr,
  input logic        trgWr,
  input logic        emsrWr,
  input logic [7:0]  lcrOut,
  input logic [15:0] divisorOut
);
  logic readReq;
  assign readReq = cs && rd && !wr;

  AST_LCR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cs && wr && addr == 3'd3) |=> (lcrOut == $past(wdata))); // R1

  AST_POP_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxPop) |-> $past(readReq && fifoStatSelN && addr == 3'd0 && !lcrOut[7])); // R2

  AST_PUSH_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (cs && wr && addr == 3'd0 && !lcrOut[7]) |=> txPush); // R2

  AST_TRG_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (cs && wr && addr == 3'd0 && lcrOut == 8'hBF) |=> (trgWr && !txPush)); // R8

  AST_DIV_ID: assert property (@(posedge clk) disable iff (!rstN)
    (readReq && fifoStatSelN && addr == 3'd1 && lcrOut[7] && lcrOut != 8'hBF &&
     divisorOut == 16'h0) |-> (rdata == DEV_ID)); // R7

  AST_REV_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (readReq && fifoStatSelN && addr == 3'd0 && lcrOut[7] && lcrOut != 8'hBF &&
     divisorOut == 16'h0) |-> (rdata == REV_CODE)); // R7

  AST_FSTAT_OVERRIDE: assert property (@(posedge clk) disable iff (!rstN)
    (readReq && !fifoStatSelN) |-> (rdata == fifoStat)); // R9

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rstN)
    !readReq |-> (rdata == 8'h00)); // R10

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxPop, txPush, fcrWr, trgWr, emsrWr})); // R11
endmodule

bind uart_bank_regs uart_bank_regs_chk #(.REV_CODE(REV_CODE), .DEV_ID(DEV_ID)) i_chk (.*);

// File: tb/test_uart_bank_regs.sv
module test_uart_bank_regs;
  localparam logic [7:0] REV = 8'h02;
  localparam logic [7:0] DID = 8'h64;

  logic clk = 1'b0, rstN = 1'b0;
  logic cs = 0, rd = 0, wr = 0, fifoStatSelN = 1;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rxData = 0, isrIn = 0, lsrIn = 0, msrIn = 0, fifoLevel = 0, fifoStat = 0;
  logic [7:0] rdata, strbData, lcrOut, ierOut, mcrOut, fctrOut, efrOut;
  logic rxPop, txPush, fcrWr, trgWr, emsrWr;
  logic [15:0] divisorOut, xonChars, xoffChars;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [7:0] mLcr = 0, mIer = 0, mMcr = 0, mSpr = 0, mFctr = 0, mEfr = 0;
  logic [7:0] mDll = 0, mDlm = 0, mXon1 = 0, mXon2 = 0, mXoff1 = 0, mXoff2 = 0;
  bit eRx = 0, eTx = 0, eFcr = 0, eTrg = 0, eEmsr = 0;
  logic [7:0] eData = 0;

  always #2 clk = ~clk;

  uart_bank_regs #(.REV_CODE(REV), .DEV_ID(DID)) i_uart_bank_regs (.*);

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit isEnh(); return mLcr == 8'hBF; endfunction
  function automatic bit isDiv(); return mLcr[7] && !isEnh(); endfunction

  function automatic string tagFor(logic [2:0] a, bit fsN);
    if (!fsN) return "R9";
    if (a == 3) return "R1";
    if (isEnh()) return "R8";
    if (isDiv() && a <= 1) return ({mDlm, mDll} == 0) ? "R7" : "R6";
    case (a)
      0: return "R2";
      1, 2, 4: return "R3";
      5, 6: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [7:0] expRead(logic [2:0] a, bit fsN);
    bit dz;
    dz = ({mDlm, mDll} == 16'h0);
    if (!fsN) return fifoStat;
    if (a == 3) return mLcr;
    if (isEnh()) begin
      case (a)
        0: return fifoLevel;
        1: return mFctr;
        2: return mEfr;
        4: return mXon1;
        5: return mXon2;
        6: return mXoff1;
        default: return mXoff2;
      endcase
    end
    if (isDiv() && a == 0) return dz ? REV : mDll;
    if (isDiv() && a == 1) return dz ? DID : mDlm;
    case (a)
      0: return rxData;
      1: return mIer;
      2: return isrIn;
      4: return mMcr;
      5: return lsrIn;
      6: return msrIn;
      default: return mFctr[6] ? fifoLevel : mSpr;
    endcase
  endfunction

  task automatic modelStep(bit w, bit r, logic [2:0] a, logic [7:0] d, bit fsN);
    eRx = 0; eTx = 0; eFcr = 0; eTrg = 0; eEmsr = 0; eData = 0;
    if (w) begin
      if (a == 3) mLcr = d;
      else if (isEnh()) begin
        case (a)
          0: begin eTrg = 1; eData = d; end
          1: mFctr = d;
          2: mEfr = d;
          4: mXon1 = d;
          5: mXon2 = d;
          6: mXoff1 = d;
          default: mXoff2 = d;
        endcase
      end else if (isDiv() && a == 0) mDll = d;
      else if (isDiv() && a == 1) mDlm = d;
      else begin
        case (a)
          0: begin eTx = 1; eData = d; end
          1: mIer = d;
          2: begin eFcr = 1; eData = d; end
          4: mMcr = d;
          5, 6: ;
          default: if (mFctr[6]) begin eEmsr = 1; eData = d; end else mSpr = d;
        endcase
      end
    end else if (r && fsN && a == 0 && !mLcr[7]) eRx = 1;
  endtask

  task automatic checkPrev();
    chk(rxPop == eRx, "R2 rxPop", rxPop, eRx);
    chk(txPush == eTx, "R2 txPush", txPush, eTx);
    chk(fcrWr == eFcr, "R3 fcrWr", fcrWr, eFcr);
    chk(emsrWr == eEmsr, "R5 emsrWr", emsrWr, eEmsr);
    chk(trgWr == eTrg, "R8 trgWr", trgWr, eTrg);
    if (eTx || eFcr || eEmsr || eTrg) chk(strbData == eData, "R11 strbData", strbData, eData);
    chk($countones({rxPop, txPush, fcrWr, trgWr, emsrWr}) <= 1, "R11 onehot",
        {rxPop, txPush, fcrWr, trgWr, emsrWr}, 0);
    chk(lcrOut == mLcr, "R1 lcrOut", lcrOut, mLcr);
    chk({ierOut, mcrOut} == {mIer, mMcr}, "R3 ier/mcr", {ierOut, mcrOut}, {mIer, mMcr});
    chk(divisorOut == {mDlm, mDll}, "R6 divisor", divisorOut, {mDlm, mDll});
    chk({fctrOut, efrOut} == {mFctr, mEfr}, "R8 fctr/efr", {fctrOut, efrOut}, {mFctr, mEfr});
    chk({xonChars, xoffChars} == {mXon2, mXon1, mXoff2, mXoff1}, "R8 flow chars",
        {xonChars, xoffChars}, {mXon2, mXon1, mXoff2, mXoff1});
  endtask

  task automatic doOp(bit w, bit r, logic [2:0] a, logic [7:0] d, bit fsN);
    logic [7:0] e;
    @(negedge clk);
    checkPrev();
    cs = w | r; wr = w; rd = r; addr = a; wdata = d; fifoStatSelN = fsN;
    rxData = 8'($urandom); isrIn = 8'($urandom); lsrIn = 8'($urandom);
    msrIn = 8'($urandom); fifoLevel = 8'($urandom); fifoStat = 8'($urandom);
    #1;
    if (r && !w) begin
      e = expRead(a, fsN);
      chk(rdata == e, tagFor(a, fsN), rdata, e);
    end else chk(rdata == 8'h00, "R10 idle rdata", rdata, 0);
    modelStep(w, r, a, d, fsN);
  endtask

  task automatic wrOp(logic [2:0] a, logic [7:0] d); doOp(1, 0, a, d, 1); endtask
  task automatic rdOp(logic [2:0] a); doOp(0, 1, a, 0, 1); endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk({lcrOut, ierOut, mcrOut, fctrOut, efrOut} == 0, "R10 reset regs",
        {lcrOut, ierOut, mcrOut, fctrOut, efrOut}, 0);
    chk({rxPop, txPush, fcrWr, trgWr, emsrWr} == 0, "R10 reset strobes",
        {rxPop, txPush, fcrWr, trgWr, emsrWr}, 0);
    rstN = 1;
    // normal bank directed
    wrOp(1, 8'h0F); wrOp(4, 8'h13); wrOp(7, 8'hA5);
    rdOp(1); rdOp(4); rdOp(7);
    rdOp(0); wrOp(0, 8'h41); wrOp(2, 8'h07); rdOp(2);
    // R4: writes to status locations are ignored
    wrOp(5, 8'hFF); wrOp(6, 8'hFF);
    rdOp(1); rdOp(4); rdOp(7); rdOp(5); rdOp(6);
    // R5: location 7 selector
    wrOp(3, 8'hBF); wrOp(1, 8'h40); wrOp(3, 8'h00);
    rdOp(7); wrOp(7, 8'h5A); rdOp(7);
    // R6/R7: divisor bank
    wrOp(3, 8'h80); rdOp(0); rdOp(1);
    wrOp(0, 8'h0C); rdOp(0); rdOp(1);
    wrOp(0, 8'h00); wrOp(1, 8'h01); rdOp(0); rdOp(1); wrOp(1, 8'h00); rdOp(1);
    // R8: enhanced bank
    wrOp(3, 8'hBF);
    for (int i = 0; i < 8; i++) if (i != 3) wrOp(3'(i), 8'(8'h20 + i));
    for (int i = 0; i < 8; i++) rdOp(3'(i));
    // R9: status override
    for (int i = 0; i < 8; i++) doOp(0, 1, 3'(i), 0, 0);
    wrOp(3, 8'h00);
    doOp(0, 1, 3'd0, 0, 0);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int kind;
      logic [2:0] a;
      logic [7:0] d;
      kind = $urandom_range(0, 9);
      a = 3'($urandom);
      d = 8'($urandom);
      if (kind == 0) begin
        case ($urandom_range(0, 3))
          0: d = 8'h00;
          1: d = 8'h80;
          2: d = 8'hBF;
          default: ;
        endcase
        wrOp(3, d);
      end else if (kind < 5) begin
        if ($urandom_range(0, 3) == 0) d = 8'h00;
        doOp(1, $urandom_range(0, 1) == 1, a, d, $urandom_range(0, 9) != 0);
      end else if (kind < 9) doOp(0, 1, a, 0, $urandom_range(0, 9) != 0);
      else doOp(0, 0, a, d, 1);
    end
    doOp(0, 0, 0, 0, 1);
    @(negedge clk);
    checkPrev();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1;
    $finish;
  end
endmodule